// File: doc/BRIEF.md
# Sixteen-Times Oversampling Serial Receiver with Three-Sample Voting

This block turns a single asynchronous serial line into bytes. The line idles high. A frame is a low start bit, eight data bits with the least significant first, an optional parity bit and a high stop bit. The block gets an enable tick at sixteen times the bit rate from outside. It uses that tick to place its samples near the middle of each bit period.

A bit's value is not taken from a single sample. Three neighbouring sub-samples around the middle of the bit vote, and the majority decides the level. When the three do not all agree, the byte is marked noisy but is still delivered with the majority value. Parity can be off, even or odd. The choice is taken when each frame begins.

Every finished frame appears as one byte with a single-cycle valid strobe. Three flags come with it, for parity mismatch, bad stop bit and noise. They hold their values until the next byte arrives.

Top module: `uart_rx_vote`

## Requirements
- R1: The raw line passes through a two-flop synchronizer that resets to 1. While idle, a synchronized low seen on a tick cycle starts a frame, and that tick counts as sub-sample 0 of the start bit. Cycles without `tick` never advance the receiver.
- R2: The eight data bits are assembled least significant bit first and presented on `rx_data`.
- R3: In every bit period the receiver takes sub-samples 7, 8 and 9, and the 2-of-3 majority sets the bit value.
- R4: If the three samples of any bit in a frame (start, data, parity or stop) are not all equal, `noise` is 1 for that byte. The data still uses the majority values.
- R5: If the start bit votes 1, the receiver returns to idle and delivers no byte.
- R6: `par_mode` encodes 2'b00 for no parity bit, 2'b01 for even, 2'b10 for odd and 2'b11 for no parity bit. With even parity the data plus parity bit hold an even count of ones, and with odd parity an odd count. A mismatch sets `err_parity`. With no parity, `err_parity` is 0 and the stop bit follows the eighth data bit.
- R7: A stop bit that votes 0 sets `err_frame`, and the byte is still delivered.
- R8: `rx_valid` is high for exactly one clock cycle, the one after the tick that takes the third stop-bit sample. `rx_data` and the three flags change only together with it and hold until the next byte.
- R9: `par_mode` is captured when the start bit is detected. Changes to it during a frame do not affect that frame.
- R10: After reset, `rx_valid`, `rx_data` and all flags are 0 and the receiver is idle.
- R11: The receiver is idle again right after the stop-bit vote, so a frame whose start bit follows the stop bit with no idle gap is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Enable strobe at sixteen times the bit rate |
| rx | input | 1 | Raw serial line, idle high |
| par_mode | input | 2 | Parity selection (none, even, odd, none) |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Single-cycle strobe for a new byte |
| err_parity | output | 1 | Parity mismatch on the last byte |
| err_frame | output | 1 | Stop bit read as 0 on the last byte |
| noise | output | 1 | Some bit of the last byte had disagreeing samples |

## Verification
The stop-bit decision tick does three things at once. It produces the framing verdict, it folds the stop bit's own vote into the noise flag, and it delivers the parity verdict taken one bit earlier. A collision between these results would show up in that one tick. The bench provokes it with frames that carry wrong parity, a low stop bit and a one-tick glitch inside the stop bit's vote window. Each such frame must give exactly one strobe, the correct byte and all three flags set. Random frames mix these conditions independently, and every flag is compared against a value predicted from the frame the bench built.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'b00,
        PAR_EVEN     = 2'b01,
        PAR_ODD      = 2'b10,
        PAR_NONE_ALT = 2'b11
    } par_mode_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RESET_VAL;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_maj3.sv
module uart_rx_maj3 (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic maj,
    output logic split
);

    // majority of three, and a flag when the three are not unanimous
    assign maj   = (a & b) | (a & c) | (b & c);
    assign split = (a ^ b) | (b ^ c);

endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              odd,
    input  logic              bit_in,
    output logic              mismatch
);

    logic expect_bit;

    // even: parity bit equals XOR of data; odd: its inverse
    assign expect_bit = (^data) ^ odd;
    assign mismatch   = bit_in ^ expect_bit;

endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic [1:0]        par_mode,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              err_parity,
    output logic              err_frame,
    output logic              noise
);

    localparam int SUB_W = $clog2(OVS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int MID   = OVS / 2;
    localparam logic [SUB_W-1:0] SMP_FIRST  = SUB_W'(MID - 1);
    localparam logic [SUB_W-1:0] SMP_SECOND = SUB_W'(MID);
    localparam logic [SUB_W-1:0] SMP_LAST   = SUB_W'(MID + 1);
    localparam logic [SUB_W-1:0] SUB_END    = SUB_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_END    = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [SUB_W-1:0]  sub;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              smp_a;
        logic              smp_b;
        logic              noisy;
        logic              par_on;
        logic              par_odd;
        logic              perr;
        logic [DATA_W-1:0] dout;
        logic              vld;
        logic              o_perr;
        logic              o_ferr;
        logic              o_noise;
    } regs_t;

    regs_t r_q, r_d;

    logic rx_sync;
    logic vote_bit;
    logic vote_split;
    logic par_bad;

    uart_rx_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx),
        .q     (rx_sync)
    );

    uart_rx_maj3 u_vote (
        .a     (r_q.smp_a),
        .b     (r_q.smp_b),
        .c     (rx_sync),
        .maj   (vote_bit),
        .split (vote_split)
    );

    uart_rx_parity #(
        .DATA_W (DATA_W)
    ) u_par (
        .data     (r_q.shreg),
        .odd      (r_q.par_odd),
        .bit_in   (vote_bit),
        .mismatch (par_bad)
    );

    always_comb begin
        logic vote_now;
        logic bit_end;

        r_d      = r_q;
        r_d.vld  = 1'b0;
        vote_now = (r_q.sub == SMP_LAST);
        bit_end  = (r_q.sub == SUB_END);

        if (tick) begin
            if (r_q.st == ST_IDLE) begin
                if (!rx_sync) begin
                    // this tick is sub-sample 0 of the start bit
                    r_d.st      = ST_START;
                    r_d.sub     = SUB_W'(1);
                    r_d.idx     = '0;
                    r_d.noisy   = 1'b0;
                    r_d.perr    = 1'b0;
                    r_d.par_on  = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
                    r_d.par_odd = (par_mode == PAR_ODD);
                end
            end else begin
                r_d.sub = bit_end ? '0 : r_q.sub + 1'b1;

                if (r_q.sub == SMP_FIRST)  r_d.smp_a = rx_sync;
                if (r_q.sub == SMP_SECOND) r_d.smp_b = rx_sync;
                if (vote_now)              r_d.noisy = r_q.noisy | vote_split;

                case (r_q.st)
                    ST_START: begin
                        if (vote_now && vote_bit) begin
                            r_d.st = ST_IDLE;
                        end else if (bit_end) begin
                            r_d.st = ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (vote_now) begin
                            r_d.shreg = {vote_bit, r_q.shreg[DATA_W-1:1]};
                        end
                        if (bit_end) begin
                            if (r_q.idx == IDX_END) begin
                                r_d.st = r_q.par_on ? ST_PAR : ST_STOP;
                            end else begin
                                r_d.idx = r_q.idx + 1'b1;
                            end
                        end
                    end
                    ST_PAR: begin
                        if (vote_now) r_d.perr = par_bad;
                        if (bit_end)  r_d.st   = ST_STOP;
                    end
                    ST_STOP: begin
                        if (vote_now) begin
                            r_d.st      = ST_IDLE;
                            r_d.dout    = r_q.shreg;
                            r_d.vld     = 1'b1;
                            r_d.o_perr  = r_q.perr;
                            r_d.o_ferr  = ~vote_bit;
                            r_d.o_noise = r_q.noisy | vote_split;
                        end
                    end
                    default: r_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_data    = r_q.dout;
    assign rx_valid   = r_q.vld;
    assign err_parity = r_q.o_perr;
    assign err_frame  = r_q.o_ferr;
    assign noise      = r_q.o_noise;

endmodule

// File: rtl/uart_rx_vote_chk.sv
module uart_rx_vote_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              rx_s,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              err_parity,
    input logic              err_frame,
    input logic              noise
);

    // R8: strobe lasts a single cycle
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8: byte and flags change only together with the strobe
    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(err_parity)
                       && $stable(err_frame) && $stable(noise)));

    // R1: nothing advances without a tick
    assert_valid_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(tick));

    // R7: with unanimous samples the last stop sample decides the framing flag
    assert_frame_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !noise) |-> ($past(rx_s) != err_frame));

    // R10: outputs are never unknown once out of reset
    assert_known_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({rx_valid, rx_data, err_parity, err_frame, noise}));

endmodule

bind uart_rx_vote uart_rx_vote_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .rx_s       (rx_sync),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .noise      (noise)
);

// File: tb/uart_rx_vote_bench.sv
module uart_rx_vote_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic [1:0] par_mode = 2'b00;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       err_parity;
    logic       err_frame;
    logic       noise;

    int tests = 0;
    int fails = 0;
    int vcount = 0;
    logic [7:0] cap_data = '0;
    logic [7:0] cap_prev = '0;
    logic cap_perr = 1'b0, cap_ferr = 1'b0, cap_noise = 1'b0;

    uart_rx_vote u_uart_rx_vote (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rx         (rx),
        .par_mode   (par_mode),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .err_parity (err_parity),
        .err_frame  (err_frame),
        .noise      (noise)
    );

    always #2 clk = ~clk;

    // tick on one cycle out of three
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div  = (div == 2) ? 0 : div + 1;
            tick = (div == 0);
        end
    end

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            vcount    = vcount + 1;
            cap_prev  = cap_data;
            cap_data  = rx_data;
            cap_perr  = err_parity;
            cap_ferr  = err_frame;
            cap_noise = noise;
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests = tests + 1;
        fails = fails + 1;
        $display("FAIL watchdog: run hung, act=running exp=done");
        summary();
        $finish;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_par(input logic [7:0] d, input logic [1:0] m);
        return (^d) ^ (m == 2'b10);
    endfunction

    function automatic bit has_par(input logic [1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction

    // hold a line value for one tick slot
    task automatic slot(input logic v);
        rx = v;
        do @(posedge clk); while (tick !== 1'b1);
        @(negedge clk);
    endtask

    task automatic send_bit(input logic v, input bit glitch);
        for (int t = 0; t < 16; t++) slot((glitch && t == 8) ? ~v : v);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic [1:0] mode,
                              input bit flip, input bit stop_low, input int gbit,
                              input bit do_sw, input logic [1:0] mid_mode,
                              input int gap);
        bit pe;
        pe = has_par(mode);
        par_mode = mode;
        send_bit(1'b0, gbit == 0);
        if (do_sw) par_mode = mid_mode;
        for (int i = 0; i < 8; i++) send_bit(d[i], gbit == i + 1);
        if (pe) send_bit(exp_par(d, mode) ^ flip, gbit == 9);
        send_bit(~stop_low, gbit == (pe ? 10 : 9));
        for (int g = 0; g < gap; g++) slot(1'b1);
    endtask

    task automatic run_frame(input string req, input logic [7:0] d,
                             input logic [1:0] mode, input bit flip,
                             input bit stop_low, input int gbit);
        int v0;
        v0 = vcount;
        send_frame(d, mode, flip, stop_low, gbit, 1'b0, 2'b00, 24);
        chk(req, "strobe count", vcount - v0, 1);
        chk(req, "data", cap_data, d);
        chk(req, "parity flag", cap_perr, has_par(mode) & flip);
        chk(req, "frame flag", cap_ferr, stop_low);
        chk(req, "noise flag", cap_noise, gbit >= 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        // R10: reset state
        chk("R10", "valid", rx_valid, 0);
        chk("R10", "data", rx_data, 0);
        chk("R10", "flags", {err_parity, err_frame, noise}, 0);
        rst_n = 1'b1;
        for (int g = 0; g < 4; g++) slot(1'b1);
        chk("R10", "no strobe on idle line", vcount, 0);

        // R1, R2: plain frames, LSB first
        run_frame("R1", 8'hA5, 2'b00, 0, 0, -1);
        run_frame("R2", 8'h01, 2'b00, 0, 0, -1);
        run_frame("R2", 8'h80, 2'b00, 0, 0, -1);
        // R6: parity modes
        run_frame("R6", 8'h37, 2'b01, 0, 0, -1);
        run_frame("R6", 8'h37, 2'b01, 1, 0, -1);
        run_frame("R6", 8'h5C, 2'b10, 0, 0, -1);
        run_frame("R6", 8'h5C, 2'b10, 1, 0, -1);
        run_frame("R6", 8'hC3, 2'b11, 0, 0, -1);
        // R3, R4: glitched samples inside the vote window
        run_frame("R3", 8'h6E, 2'b00, 0, 0, 3);
        run_frame("R4", 8'h19, 2'b01, 0, 0, 0);
        run_frame("R4", 8'hF0, 2'b10, 0, 0, 9);
        // R7: bad stop bit, byte still delivered
        run_frame("R7", 8'h4B, 2'b00, 0, 1, -1);
        // parity, framing and noise on one stop decision
        run_frame("R7", 8'h92, 2'b01, 1, 1, 10);

        // R5: short low pulse is a false start
        begin
            int v0;
            v0 = vcount;
            for (int t = 0; t < 5; t++) slot(1'b0);
            for (int t = 0; t < 40; t++) slot(1'b1);
            chk("R5", "no strobe after false start", vcount - v0, 0);
            chk("R5", "previous byte held", rx_data, 8'h92);
        end
        run_frame("R5", 8'h3D, 2'b00, 0, 0, -1);

        // R9: mode changes mid-frame are ignored
        begin
            int v0;
            v0 = vcount;
            send_frame(8'h37, 2'b01, 0, 0, -1, 1'b1, 2'b10, 24);
            chk("R9", "strobe count", vcount - v0, 1);
            chk("R9", "parity flag", cap_perr, 0);
            v0 = vcount;
            send_frame(8'h21, 2'b00, 0, 0, -1, 1'b1, 2'b01, 24);
            chk("R9", "strobe count none-to-even", vcount - v0, 1);
            chk("R9", "data none-to-even", cap_data, 8'h21);
        end

        // R11: back-to-back frames without idle gap
        begin
            int v0;
            v0 = vcount;
            send_frame(8'hE7, 2'b00, 0, 0, -1, 1'b0, 2'b00, 0);
            send_frame(8'h18, 2'b10, 0, 0, -1, 1'b0, 2'b00, 24);
            chk("R11", "two strobes", vcount - v0, 2);
            chk("R11", "first byte", cap_prev, 8'hE7);
            chk("R11", "second byte", cap_data, 8'h18);
            // R8: values hold after the strobe
            for (int g = 0; g < 10; g++) slot(1'b1);
            chk("R8", "data held", rx_data, 8'h18);
            chk("R8", "flags held", {err_parity, err_frame, noise}, 0);
            chk("R8", "strobe low", rx_valid, 0);
        end

        // random frames
        for (int k = 0; k < 30; k++) begin
            logic [7:0] d;
            logic [1:0] m;
            bit fl, sl;
            int gs, gmax;
            d    = 8'($urandom);
            m    = 2'($urandom % 4);
            fl   = 1'($urandom % 2);
            sl   = ($urandom % 6) == 0;
            gmax = has_par(m) ? 10 : 9;
            gs   = int'($urandom % 16) - 1;
            if (gs > gmax) gs = -1;
            run_frame("R4", d, m, fl, sl, gs);
        end

        summary();
        $finish;
    end

endmodule